// File: doc/BRIEF.md
# Byte-Lane Serial Port Register Window

This block presents the programmer-visible register set of a classic 16550/16750-style serial port on a simple memory-mapped bus. It offers eight byte-wide registers on a 32-bit stride. A transmit write does not feed a bit shifter. The byte is pushed out at once on a parallel byte stream with a single-cycle valid strobe. This suits simulation consoles and debug channels that only need software-compatible register behaviour.

The bus side has a request, a write enable, an address, write data, read data, an error flag and a response strobe. Every access is answered exactly one cycle after its request. The line-control register's top bit switches indices 0 and 1 between the data/interrupt-enable pair and the two divisor bytes. The line status always reports the transmitter as idle. The identification register shows only whether the FIFO mode was switched on.

Top module: `ser_regwin`

## Requirements
- R1: A request whose address has bit 1 or bit 0 set is answered with `err_o`=1 and changes no register and sends no byte. Any aligned request answers with `err_o`=0, and a refused read returns zero.
- R2: The register index is address bits [4:2]: 0 data/divisor-low, 1 interrupt-enable/divisor-high, 2 FIFO control/identification, 3 line control, 4 modem control, 5 line status, 6 modem status, 7 scratch. Address bits above bit 4 are ignored.
- R3: While line-control bit 7 is 1, index 0 writes and reads the divisor low byte and index 1 writes and reads the divisor high byte. These writes send no byte and leave the interrupt-enable register unchanged.
- R4: While line-control bit 7 is 0, a write to index 0 drives `tx_valid_o`=1 for exactly one cycle, with `tx_data_o` equal to the written low byte. This happens in the cycle after the request.
- R5: While line-control bit 7 is 0, a write to index 1 stores only write-data bits [3:0] in the interrupt-enable register, and bits [7:4] read as 0.
- R6: A write to index 2 sets the FIFO-enable flag to write-data bit 0. A read of index 2 returns 0xC0 when the flag is 1 and 0x00 when it is 0.
- R7: A write to index 4 stores only write-data bits [4:0]. Bits [7:5] of the modem-control register read as 0.
- R8: A read of index 5 returns the stored line-status byte with bit 5 and bit 6 forced to 1.
- R9: Indices 3, 5, 6 and 7 store the full written byte, and 3, 6 and 7 read it back unchanged.
- R10: A read of index 0 while line-control bit 7 is 0 returns 0x00.
- R11: After reset every register and the FIFO flag are zero. `rsp_valid_o` is 1 in exactly the cycle after each request and 0 otherwise.
- R12: Read-data bits above bit 7 are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW (16) | Byte address |
| wdata_i | input | DW (32) | Write data, low byte used |
| rdata_o | output | DW (32) | Read data, valid with rsp_valid_o |
| err_o | output | 1 | Misaligned access refused, valid with rsp_valid_o |
| rsp_valid_o | output | 1 | Response strobe, one cycle after req_i |
| tx_data_o | output | 8 | Transmitted byte |
| tx_valid_o | output | 1 | One-cycle strobe for tx_data_o |

## Verification
On every cycle, the assertions check several invariants. The response strobe must follow each request by one cycle. A misaligned request must raise the error and leave all stored state unchanged. Transmit strobes must carry the byte of the triggering write. The masked interrupt-enable and modem-control bits and the upper read-data bits must stay zero. Only the bench's scenarios can show the values that software reads back. These include the divisor bank switch, the 0xC0/0x00 identification code, the forced status bits, full-byte storage, the zero data read and the aliasing of high address bits, each compared against values derived from the requirements.

// File: rtl/ser_regwin_pkg.sv
package ser_regwin_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    IX_DATA  = 3'd0,
    IX_IEN   = 3'd1,
    IX_FIFO  = 3'd2,
    IX_LCTL  = 3'd3,
    IX_MCTL  = 3'd4,
    IX_LSTAT = 3'd5,
    IX_MSTAT = 3'd6,
    IX_SCR   = 3'd7
  } reg_ix_e;

  localparam int unsigned BANK_BIT  = 7;
  localparam int unsigned HOLD_BIT  = 5;
  localparam int unsigned IDLE_BIT  = 6;
  localparam int unsigned IEN_KEEP  = 4;
  localparam int unsigned MCTL_KEEP = 5;

  // keep the lowest n bits of a byte
  function automatic logic [BYTE_W-1:0] keep_low(input logic [BYTE_W-1:0] v,
                                                 input int unsigned n);
    logic [BYTE_W-1:0] m;
    for (int i = 0; i < BYTE_W; i++) m[i] = (i < n);
    return v & m;
  endfunction

  // status view: transmitter always idle
  function automatic logic [BYTE_W-1:0] status_view(input logic [BYTE_W-1:0] v);
    logic [BYTE_W-1:0] r;
    r = v;
    r[HOLD_BIT] = 1'b1;
    r[IDLE_BIT] = 1'b1;
    return r;
  endfunction

  // identification view: only the FIFO mode is reported
  function automatic logic [BYTE_W-1:0] ident_view(input logic fifo_on);
    return fifo_on ? 8'hC0 : 8'h00;
  endfunction
endpackage

// File: rtl/ser_regwin_decode.sv
module ser_regwin_decode
  import ser_regwin_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic          bank_i,
  output logic          misaligned_o,
  output reg_ix_e       ix_o,
  output logic [7:0]    wr_hot_o,
  output logic          wr_div_lo_o,
  output logic          wr_div_hi_o,
  output logic          rd_ok_o
);
  localparam int unsigned NREG = 8;

  logic acc_ok;
  logic wr_ok;

  assign misaligned_o = req_i && (addr_i[1:0] != 2'b00);
  assign ix_o         = reg_ix_e'(addr_i[4:2]);
  assign acc_ok       = req_i && !misaligned_o;
  assign wr_ok        = acc_ok && we_i;
  assign rd_ok_o      = acc_ok && !we_i;

  // divisor bank steals indices 0 and 1
  assign wr_div_lo_o  = wr_ok && bank_i && (ix_o == IX_DATA);
  assign wr_div_hi_o  = wr_ok && bank_i && (ix_o == IX_IEN);

  for (genvar g = 0; g < NREG; g++) begin : g_hot
    if (g < 2) begin : g_banked
      assign wr_hot_o[g] = wr_ok && !bank_i && (ix_o == reg_ix_e'(g));
    end else begin : g_plain
      assign wr_hot_o[g] = wr_ok && (ix_o == reg_ix_e'(g));
    end
  end

  logic unused_addr;
  if (AW > 5) begin : g_hi
    assign unused_addr = ^addr_i[AW-1:5];
  end else begin : g_nohi
    assign unused_addr = 1'b0;
  end
endmodule

// File: rtl/ser_regwin_store.sv
module ser_regwin_store
  import ser_regwin_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        wr_hot_i,
  input  logic              wr_div_lo_i,
  input  logic              wr_div_hi_i,
  input  logic [BYTE_W-1:0] wbyte_i,
  output logic [BYTE_W-1:0] div_lo_o,
  output logic [BYTE_W-1:0] div_hi_o,
  output logic [BYTE_W-1:0] ien_o,
  output logic              fifo_on_o,
  output logic [BYTE_W-1:0] lctl_o,
  output logic [BYTE_W-1:0] mctl_o,
  output logic [BYTE_W-1:0] lstat_o,
  output logic [BYTE_W-1:0] mstat_o,
  output logic [BYTE_W-1:0] scr_o,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic              tx_valid_o
);
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      div_lo_o   <= '0;
      div_hi_o   <= '0;
      ien_o      <= '0;
      fifo_on_o  <= 1'b0;
      lctl_o     <= '0;
      mctl_o     <= '0;
      lstat_o    <= '0;
      mstat_o    <= '0;
      scr_o      <= '0;
      tx_data_o  <= '0;
      tx_valid_o <= 1'b0;
    end else begin
      tx_valid_o <= wr_hot_i[IX_DATA];
      if (wr_hot_i[IX_DATA])  tx_data_o <= wbyte_i;
      if (wr_div_lo_i)        div_lo_o  <= wbyte_i;
      if (wr_div_hi_i)        div_hi_o  <= wbyte_i;
      if (wr_hot_i[IX_IEN])   ien_o     <= keep_low(wbyte_i, IEN_KEEP);
      if (wr_hot_i[IX_FIFO])  fifo_on_o <= wbyte_i[0];
      if (wr_hot_i[IX_LCTL])  lctl_o    <= wbyte_i;
      if (wr_hot_i[IX_MCTL])  mctl_o    <= keep_low(wbyte_i, MCTL_KEEP);
      if (wr_hot_i[IX_LSTAT]) lstat_o   <= wbyte_i;
      if (wr_hot_i[IX_MSTAT]) mstat_o   <= wbyte_i;
      if (wr_hot_i[IX_SCR])   scr_o     <= wbyte_i;
    end
  end

  // R5
  ien_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ien_o[7:4] == 4'h0);
  // R7
  mctl_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mctl_o[7:5] == 3'h0);
  // R3
  div_no_tx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_div_lo_i || wr_div_hi_i) |=> !tx_valid_o);
endmodule

// File: rtl/ser_regwin_rdmux.sv
module ser_regwin_rdmux
  import ser_regwin_pkg::*;
(
  input  reg_ix_e           ix_i,
  input  logic              bank_i,
  input  logic [BYTE_W-1:0] div_lo_i,
  input  logic [BYTE_W-1:0] div_hi_i,
  input  logic [BYTE_W-1:0] ien_i,
  input  logic              fifo_on_i,
  input  logic [BYTE_W-1:0] lctl_i,
  input  logic [BYTE_W-1:0] mctl_i,
  input  logic [BYTE_W-1:0] lstat_i,
  input  logic [BYTE_W-1:0] mstat_i,
  input  logic [BYTE_W-1:0] scr_i,
  output logic [BYTE_W-1:0] rbyte_o
);
  always_comb begin
    unique case (ix_i)
      IX_DATA:  rbyte_o = bank_i ? div_lo_i : '0;
      IX_IEN:   rbyte_o = bank_i ? div_hi_i : ien_i;
      IX_FIFO:  rbyte_o = ident_view(fifo_on_i);
      IX_LCTL:  rbyte_o = lctl_i;
      IX_MCTL:  rbyte_o = mctl_i;
      IX_LSTAT: rbyte_o = status_view(lstat_i);
      IX_MSTAT: rbyte_o = mstat_i;
      IX_SCR:   rbyte_o = scr_i;
      default:  rbyte_o = '0;
    endcase
  end
endmodule

// File: rtl/ser_regwin.sv
module ser_regwin
  import ser_regwin_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          err_o,
  output logic          rsp_valid_o,
  output logic [7:0]    tx_data_o,
  output logic          tx_valid_o
);
  localparam int unsigned PAD_W = DW - BYTE_W;

  // named internal events
  logic              misaligned;
  reg_ix_e           ix;
  logic [7:0]        wr_hot;
  logic              wr_div_lo, wr_div_hi, rd_ok;
  logic [BYTE_W-1:0] div_lo, div_hi, ien, lctl, mctl, lstat, mstat, scr;
  logic              fifo_on;
  logic              bank;
  logic [BYTE_W-1:0] rbyte;
  logic [BYTE_W-1:0] wbyte;

  assign bank  = lctl[BANK_BIT];
  assign wbyte = wdata_i[BYTE_W-1:0];

  ser_regwin_decode #(.AW(AW)) u_dec (
    .req_i(req_i), .we_i(we_i), .addr_i(addr_i), .bank_i(bank),
    .misaligned_o(misaligned), .ix_o(ix), .wr_hot_o(wr_hot),
    .wr_div_lo_o(wr_div_lo), .wr_div_hi_o(wr_div_hi), .rd_ok_o(rd_ok)
  );

  ser_regwin_store u_st (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_hot_i(wr_hot),
    .wr_div_lo_i(wr_div_lo), .wr_div_hi_i(wr_div_hi), .wbyte_i(wbyte),
    .div_lo_o(div_lo), .div_hi_o(div_hi), .ien_o(ien), .fifo_on_o(fifo_on),
    .lctl_o(lctl), .mctl_o(mctl), .lstat_o(lstat), .mstat_o(mstat),
    .scr_o(scr), .tx_data_o(tx_data_o), .tx_valid_o(tx_valid_o)
  );

  ser_regwin_rdmux u_rd (
    .ix_i(ix), .bank_i(bank), .div_lo_i(div_lo), .div_hi_i(div_hi),
    .ien_i(ien), .fifo_on_i(fifo_on), .lctl_i(lctl), .mctl_i(mctl),
    .lstat_i(lstat), .mstat_i(mstat), .scr_i(scr), .rbyte_o(rbyte)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      err_o       <= 1'b0;
      rdata_o     <= '0;
    end else begin
      rsp_valid_o <= req_i;
      err_o       <= misaligned;
      rdata_o     <= rd_ok ? {{PAD_W{1'b0}}, rbyte} : '0;
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata_i[DW-1:BYTE_W];

  // R11
  rsp_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o);
  // R11
  rsp_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rsp_valid_o);
  // R1
  misalign_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i[1:0] != 2'b00) |=> err_o);
  // R1
  misalign_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i[1:0] != 2'b00) |=>
      ($stable(lctl) && $stable(scr) && $stable(ien) && $stable(div_lo)
       && $stable(fifo_on) && !tx_valid_o));
  // R4
  tx_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i[4:0] == 5'd0 && !lctl[7]) |=>
      (tx_valid_o && tx_data_o == $past(wdata_i[7:0])));
  // R4
  tx_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> $past(req_i && we_i));
  // R12
  rdata_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DW-1:BYTE_W] == '0);
endmodule

// File: tb/sim_ser_regwin.sv
module sim_ser_regwin;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err, rsp_valid, tx_valid;
  logic [7:0]  tx_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ser_regwin u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .err_o(err), .rsp_valid_o(rsp_valid),
    .tx_data_o(tx_data), .tx_valid_o(tx_valid)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  // one bus access; response sampled at the next falling edge
  logic [31:0] r_data;
  logic        r_err, r_tv;
  logic [7:0]  r_td;
  task automatic acc(input logic w, input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    r_data = rdata; r_err = err; r_tv = tx_valid; r_td = tx_data;
    chk("R11 rsp_valid after request", {31'b0, rsp_valid}, 32'h1);
  endtask

  task automatic wr(input int ix, input logic [7:0] d);
    acc(1'b1, 16'(ix * 4), {24'hABCDEF, d});
  endtask

  task automatic rd(input int ix);
    acc(1'b0, 16'(ix * 4), 32'h0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R11 no rsp when idle", {31'b0, rsp_valid}, 32'h0);
    rd(3); chk("R11 line ctl reset", r_data, 32'h0);
    rd(7); chk("R11 scratch reset", r_data, 32'h0);
    rd(2); chk("R11 fifo flag reset", r_data, 32'h0);
    rd(5); chk("R8 status after reset", r_data, 32'h60);
  endtask

  task automatic t_tx;
    wr(0, 8'h41);
    chk("R4 tx valid", {31'b0, r_tv}, 32'h1);
    chk("R4 tx data", {24'b0, r_td}, 32'h41);
    chk("R1 aligned no err", {31'b0, r_err}, 32'h0);
    @(negedge clk);
    chk("R4 tx single cycle", {31'b0, tx_valid}, 32'h0);
    wr(0, 8'hFE);
    chk("R4 tx data second", {24'b0, r_td}, 32'hFE);
    rd(0); chk("R10 data read zero", r_data, 32'h0);
    chk("R4 read sends nothing", {31'b0, r_tv}, 32'h0);
  endtask

  task automatic t_bank;
    wr(1, 8'h5A);
    wr(3, 8'h83);
    wr(0, 8'h1B);
    chk("R3 divisor write sends no byte", {31'b0, r_tv}, 32'h0);
    wr(1, 8'hC7);
    rd(0); chk("R3 divisor low", r_data, 32'h1B);
    rd(1); chk("R3 divisor high", r_data, 32'hC7);
    wr(3, 8'h03);
    rd(1); chk("R3 ien untouched by divisor", r_data, 32'hA);
    rd(0); chk("R10 data read zero after bank", r_data, 32'h0);
    wr(3, 8'h83);
    rd(0); chk("R3 divisor low kept", r_data, 32'h1B);
    wr(3, 8'h03);
  endtask

  task automatic t_ien;
    wr(1, 8'hFF);
    rd(1); chk("R5 ien low nibble", r_data, 32'hF);
    wr(1, 8'h36);
    rd(1); chk("R5 ien mask", r_data, 32'h6);
  endtask

  task automatic t_fifo;
    wr(2, 8'h01);
    rd(2); chk("R6 ident fifo on", r_data, 32'hC0);
    wr(2, 8'hFE);
    rd(2); chk("R6 ident fifo off", r_data, 32'h00);
  endtask

  task automatic t_mctl;
    wr(4, 8'hFF);
    rd(4); chk("R7 mctl mask", r_data, 32'h1F);
    wr(4, 8'hA5);
    rd(4); chk("R7 mctl mask 2", r_data, 32'h05);
  endtask

  task automatic t_plain;
    wr(5, 8'h81);
    rd(5); chk("R8 status forced bits", r_data, 32'hE1);
    wr(5, 8'h00);
    rd(5); chk("R9 R8 status stored", r_data, 32'h60);
    wr(6, 8'h9C);
    rd(6); chk("R9 modem status", r_data, 32'h9C);
    wr(7, 8'hFF);
    rd(7); chk("R9 scratch", r_data, 32'hFF);
    wr(3, 8'h7E);
    rd(3); chk("R9 line ctl", r_data, 32'h7E);
    wr(3, 8'h03);
    chk("R12 upper zero", {24'b0, r_data[31:8]}, 32'h0);
  endtask

  task automatic t_alias;
    acc(1'b1, 16'h003C, 32'h0000_0066);
    rd(7); chk("R2 high address bits ignored", r_data, 32'h66);
    acc(1'b0, 16'h0F1C, 32'h0);
    chk("R2 alias read", r_data, 32'h66);
  endtask

  task automatic t_misalign;
    acc(1'b1, 16'h001D, 32'hAA);
    chk("R1 misaligned err", {31'b0, r_err}, 32'h1);
    rd(7); chk("R1 scratch unchanged", r_data, 32'h66);
    acc(1'b1, 16'h0002, 32'h55);
    chk("R1 misaligned sends nothing", {31'b0, r_tv}, 32'h0);
    acc(1'b0, 16'h000F, 32'h0);
    chk("R1 misaligned read err", {31'b0, r_err}, 32'h1);
    chk("R1 misaligned read data", r_data, 32'h0);
    rd(3); chk("R1 line ctl unchanged", r_data, 32'h03);
    chk("R1 aligned read no err", {31'b0, r_err}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_tx();
    t_ien();
    t_bank();
    t_fifo();
    t_mctl();
    t_plain();
    t_alias();
    t_misalign();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule